// File: doc/BRIEF.md
# Backplane Bus Master Strobe Sequencer

This block runs one master data-transfer cycle at a time on an asynchronous parallel backplane. It accepts a local request holding an address, a six-bit address modifier, two byte-lane enables, a direction and write data. It then drives the address strobe, the two data strobes and the write line. It waits for the slave's acknowledge, which arrives on an unsynchronized active-low input, and finishes the cycle in one of two termination styles.

In release-all style, acknowledge frees every strobe in the same clock. In coupled style, acknowledge frees only the data strobes. The address strobe stays low until the slave withdraws its acknowledge. The style is picked per cycle from the address space the modifier names, and each space has its own configuration bit.

A slave that keys its acknowledge off the address strobe will never let go in coupled style. A programmable cycle counter breaks that deadlock, and it also catches a slave that never answers. In both cases the block releases every strobe and pulses a timeout flag.

Top module: `strobe_cycle_master`

## Requirements
- R1: After reset, asN is 1, dsN is 2'b11, done and timeout are 0, and reqReady is 1 while dtackN is high.
- R2: On the clock edge that accepts a request (reqValid and reqReady both high), address, modifier, write data and busWriteN (0 for a write) are loaded and driven from that edge on. asN falls one edge later. dsN becomes ~reqLanes one edge after that, with bit 0 carrying lane 0.
- R3: The cycle is in the wide space when modifier bits [5:4] are 2'b11, and then it takes its style from cfgCoupled24. Any other modifier takes its style from cfgCoupled16. A bit value of 1 selects coupled style.
- R4: Release-all style: on the edge where synchronized acknowledge is first seen low, asN and dsN go high together, and done pulses for one cycle.
- R5: Coupled style: on that edge only dsN goes high and asN stays low. asN rises, with a done pulse, on the edge where synchronized acknowledge is seen high again.
- R6: dtackN passes through two flip-flops. For a read, rdData takes busDin on the edge where the synchronized acknowledge is first low, and it holds that value afterwards.
- R7: Let T be cfgTimeout and let the accepting edge be edge 0. If acknowledge never arrives, all strobes are released and timeout pulses for one cycle after edge T+3. While waiting for release in coupled style, the same limit of T+1 clocks applies from the edge that frees the data strobes.
- R8: In coupled style, a slave that holds acknowledge for as long as asN is low ends in a timeout. The freed asN lets the slave release, and the block becomes ready again.
- R9: If the acknowledge is recognized on the same edge as the counter expires, the cycle completes normally, with done and no timeout.
- R10: reqReady is 0 while the synchronized acknowledge is low. A request presented then is ignored: asN stays high and busAddr keeps its value.
- R11: done and timeout are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Local request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Request address |
| reqMod | input | 6 | Address modifier |
| reqLanes | input | 2 | Byte-lane enables, bit 0 is lane 0 |
| reqWrite | input | 1 | 1 for a write |
| reqWdata | input | DATA_W | Write data |
| cfgCoupled16 | input | 1 | Coupled style for the narrow space |
| cfgCoupled24 | input | 1 | Coupled style for the wide space |
| cfgTimeout | input | CNT_W | Wait limit T |
| busAddr | output | ADDR_W | Bus address |
| busMod | output | 6 | Bus address modifier |
| busWriteN | output | 1 | Active-low write line |
| busDout | output | DATA_W | Bus write data |
| busDin | input | DATA_W | Bus read data |
| asN | output | 1 | Active-low address strobe |
| dsN | output | 2 | Active-low data strobes |
| dtackN | input | 1 | Active-low acknowledge, asynchronous |
| rdData | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle pulse on normal completion |
| timeout | output | 1 | One-cycle pulse on abort |

## Verification
The slave's acknowledge and the expiry of the wait counter can land on the same clock edge. The bench provokes this by having its slave model drive dtackN low at a chosen number of clocks after the accepting edge. At one placement the synchronized acknowledge reaches the sequencer exactly on the expiry edge, and at the next placement it arrives one clock too late. The first run must end in done with no timeout, and the second in timeout with no done. An assertion also keeps the two pulses apart in every cycle.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ASRT,
    ST_WACK,
    ST_WREL
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic capture;
    logic driveAs;
    logic driveDs;
  } seqCtl_t;

endpackage

// File: rtl/bcm_datapath.sv
module bcm_datapath
  import bcm_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int MOD_W       = 6,
  parameter int LANE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MOD_W-1:0]  reqMod,
  input  logic [LANE_W-1:0] reqLanes,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  input  logic              dtackN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [MOD_W-1:0]  busMod,
  output logic              busWriteN,
  output logic [DATA_W-1:0] busDout,
  output logic              asN,
  output logic [LANE_W-1:0] dsN,
  output logic [DATA_W-1:0] rdData,
  output logic              dtackLow,
  output logic              spaceWide
);

  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [LANE_W-1:0]   laneQ;
  logic                writeQ;
  logic [SYNC_TOP:0]   syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr <= '0;
      busMod  <= '0;
      busDout <= '0;
      laneQ   <= '0;
      writeQ  <= 1'b0;
    end else if (ctl.loadReq) begin
      busAddr <= reqAddr;
      busMod  <= reqMod;
      busDout <= reqWdata;
      laneQ   <= reqLanes;
      writeQ  <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_TOP-1:0], dtackN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capture) rdData <= busDin;
  end

  assign dtackLow  = !syncQ[SYNC_TOP];
  assign spaceWide = (busMod[MOD_W-1 -: 2] == 2'b11);
  assign busWriteN = !writeQ;
  assign asN       = !ctl.driveAs;
  assign dsN       = ctl.driveDs ? ~laneQ : '1;

  // R2: data strobes only after the address strobe was already low
  a_r2_ds_after_as: assert property (@(posedge clk) disable iff (!rstN)
    (dsN != '1) |-> $past(!asN));

  // R10: no request is loaded while acknowledge is still held
  a_r10_load_needs_release: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadReq |-> !dtackLow);

endmodule

// File: rtl/bcm_ctrl.sv
module bcm_ctrl
  import bcm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             dtackLow,
  input  logic             spaceWide,
  input  logic             cfgCoupled16,
  input  logic             cfgCoupled24,
  input  logic [CNT_W-1:0] cfgTimeout,
  output seqCtl_t          ctl,
  output logic             reqReady,
  output logic             done,
  output logic             timeout
);

  seqState_e        state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic             coupled, expired, finOk, finTmo;

  assign coupled  = spaceWide ? cfgCoupled24 : cfgCoupled16;
  assign expired  = (cnt == cfgTimeout);
  assign reqReady = (state == ST_IDLE) && !dtackLow;

  always_comb begin
    stateNext = state;
    finOk     = 1'b0;
    finTmo    = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid && reqReady) stateNext = ST_ADDR;
      ST_ADDR: stateNext = ST_ASRT;
      ST_ASRT: stateNext = ST_WACK;
      ST_WACK: begin
        if (dtackLow) begin
          stateNext = coupled ? ST_WREL : ST_IDLE;
          finOk     = !coupled;
        end else if (expired) begin
          stateNext = ST_IDLE;
          finTmo    = 1'b1;
        end
      end
      ST_WREL: begin
        if (!dtackLow) begin
          stateNext = ST_IDLE;
          finOk     = 1'b1;
        end else if (expired) begin
          stateNext = ST_IDLE;
          finTmo    = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.loadReq = (state == ST_IDLE) && reqValid && reqReady;
    ctl.capture = (state == ST_WACK) && dtackLow;
    ctl.driveAs = (state == ST_ASRT) || (state == ST_WACK) || (state == ST_WREL);
    ctl.driveDs = (state == ST_WACK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      state   <= stateNext;
      done    <= finOk;
      timeout <= finTmo;
      if (stateNext != state) cnt <= '0;
      else if (cnt != '1)     cnt <= cnt + 1'b1;
    end
  end

  // R4: release-all frees every strobe on the acknowledge edge
  a_r4_release_together: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WACK && dtackLow && !coupled) |=> (!ctl.driveAs && !ctl.driveDs && done));

  // R5: coupled style keeps the address strobe after the acknowledge edge
  a_r5_coupled_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WACK && dtackLow && coupled) |=> (ctl.driveAs && !ctl.driveDs && !done));

  // R7: the wait counter never passes the programmed limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WACK || state == ST_WREL) |-> (cnt <= cfgTimeout));

  // R11: completion and abort are exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeout));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/strobe_cycle_master.sv
module strobe_cycle_master
  import bcm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [5:0]        reqMod,
  input  logic [1:0]        reqLanes,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cfgCoupled16,
  input  logic              cfgCoupled24,
  input  logic [CNT_W-1:0]  cfgTimeout,
  output logic [ADDR_W-1:0] busAddr,
  output logic [5:0]        busMod,
  output logic              busWriteN,
  output logic [DATA_W-1:0] busDout,
  input  logic [DATA_W-1:0] busDin,
  output logic              asN,
  output logic [1:0]        dsN,
  input  logic              dtackN,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              timeout
);

  seqCtl_t ctl;
  logic    dtackLow;
  logic    spaceWide;

  bcm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .dtackLow(dtackLow),
    .spaceWide(spaceWide), .cfgCoupled16(cfgCoupled16), .cfgCoupled24(cfgCoupled24),
    .cfgTimeout(cfgTimeout), .ctl(ctl), .reqReady(reqReady),
    .done(done), .timeout(timeout)
  );

  bcm_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MOD_W(6), .LANE_W(2), .SYNC_STAGES(2)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqMod(reqMod),
    .reqLanes(reqLanes), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .busDin(busDin), .dtackN(dtackN), .busAddr(busAddr), .busMod(busMod),
    .busWriteN(busWriteN), .busDout(busDout), .asN(asN), .dsN(dsN),
    .rdData(rdData), .dtackLow(dtackLow), .spaceWide(spaceWide)
  );

endmodule

// File: tb/tb_strobe_cycle_master.sv
module tb_strobe_cycle_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic [5:0]  reqMod = '0;
  logic [1:0]  reqLanes = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        cfgCoupled16 = 1'b0;
  logic        cfgCoupled24 = 1'b1;
  logic [7:0]  cfgTimeout = 8'd8;
  logic [23:0] busAddr;
  logic [5:0]  busMod;
  logic        busWriteN;
  logic [15:0] busDout;
  logic [15:0] busDin = '0;
  logic        asN;
  logic [1:0]  dsN;
  logic        dtackN = 1'b1;
  logic [15:0] rdData;
  logic        done;
  logic        timeout;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  strobe_cycle_master dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqMod(reqMod), .reqLanes(reqLanes), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .cfgCoupled16(cfgCoupled16), .cfgCoupled24(cfgCoupled24),
    .cfgTimeout(cfgTimeout), .busAddr(busAddr), .busMod(busMod), .busWriteN(busWriteN),
    .busDout(busDout), .busDin(busDin), .asN(asN), .dsN(dsN), .dtackN(dtackN),
    .rdData(rdData), .done(done), .timeout(timeout)
  );

  typedef struct packed {
    logic [5:0]  mod;
    logic        wr;
    logic [1:0]  lanes;
    logic [23:0] addr;
    logic [15:0] data;
    logic        c16;
    logic        c24;
    logic [7:0]  ackAt;      // clock count after accept, 0 = never
    logic        relOnAs;    // slave keys acknowledge off AS
    logic [1:0]  expRes;     // 1 done, 2 timeout
    logic        expCoupled;
    logic        expReady;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{6'h29, 1'b0, 2'b11, 24'h001234, 16'hA5A5, 1'b0, 1'b1, 8'd5, 1'b0, 2'd1, 1'b0, 1'b0},
    '{6'h39, 1'b0, 2'b11, 24'h123456, 16'h5A5A, 1'b0, 1'b1, 8'd5, 1'b0, 2'd1, 1'b1, 1'b1},
    '{6'h3D, 1'b1, 2'b01, 24'h00FF00, 16'h1111, 1'b0, 1'b1, 8'd6, 1'b0, 2'd1, 1'b1, 1'b1},
    '{6'h2D, 1'b1, 2'b10, 24'h000042, 16'h2222, 1'b0, 1'b1, 8'd4, 1'b0, 2'd1, 1'b0, 1'b0},
    '{6'h3A, 1'b0, 2'b11, 24'h0ABCDE, 16'h3333, 1'b0, 1'b1, 8'd5, 1'b1, 2'd2, 1'b1, 1'b0},
    '{6'h3A, 1'b0, 2'b11, 24'h0ABCDE, 16'h4444, 1'b0, 1'b0, 8'd5, 1'b1, 2'd1, 1'b0, 1'b0},
    '{6'h29, 1'b0, 2'b11, 24'h000010, 16'h0000, 1'b0, 1'b1, 8'd0, 1'b0, 2'd2, 1'b0, 1'b1},
    '{6'h29, 1'b0, 2'b10, 24'h000020, 16'h7777, 1'b1, 1'b0, 8'd5, 1'b0, 2'd1, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one bus cycle with a behavioural slave; returns result kind and count
  task automatic run_cycle(input vec_t v, output int res, output int resN,
                           output bit coup, output bit ready, output bit allHigh);
    res = 0; resN = 0; coup = 0; allHigh = 0;
    while (!reqReady) @(negedge clk);
    reqMod = v.mod; reqWrite = v.wr; reqLanes = v.lanes;
    reqAddr = v.addr; reqWdata = v.data; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 1; n < 80; n++) begin
      if (n > 1) @(negedge clk);
      if (n == 1) begin
        check(busAddr == v.addr && busMod == v.mod && busWriteN == !v.wr && asN,
              "R2", "address phase", {busAddr, busMod}, {v.addr, v.mod});
        if (v.wr) check(busDout == v.data, "R2", "write data", busDout, v.data);
      end
      if (n == 2) check(!asN && dsN == 2'b11, "R2", "AS leads DS", {asN, dsN}, 3'b011);
      if (n == 3) check(!asN && dsN == ~v.lanes, "R2", "DS lanes", dsN, ~v.lanes);
      if (dtackN == 1'b0 && (v.relOnAs ? asN : (dsN == 2'b11))) dtackN = 1'b1;
      if (v.ackAt != 0 && n == int'(v.ackAt)) begin
        dtackN = 1'b0;
        busDin = v.data;
      end
      if (n > 3 && dsN == 2'b11 && !asN) coup = 1;
      if (done || timeout) begin
        res = done ? 1 : 2;
        resN = n;
        allHigh = asN && (dsN == 2'b11);
        break;
      end
    end
    @(negedge clk);
    ready = reqReady;
    for (int k = 0; k < 20 && dtackN == 1'b0; k++) begin
      if (v.relOnAs ? asN : (dsN == 2'b11)) dtackN = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    int res, resN;
    bit coup, ready, allHigh;
    vec_t v;
    repeat (3) @(negedge clk);
    // R1: reset state, sampled during and after reset
    check(asN && dsN == 2'b11 && !done && !timeout, "R1", "strobes in reset",
          {asN, dsN, done, timeout}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    check(asN && dsN == 2'b11 && !done && !timeout && reqReady, "R1", "idle after reset",
          {asN, dsN, done, timeout, reqReady}, 6'b111001);

    // vector table: R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      cfgCoupled16 = v.c16; cfgCoupled24 = v.c24; cfgTimeout = 8'd8;
      run_cycle(v, res, resN, coup, ready, allHigh);
      check(res == int'(v.expRes), (v.expRes == 2) ? "R8" : "R4", $sformatf("vec %0d result", i),
            res, v.expRes);
      check(coup == v.expCoupled, v.expCoupled ? "R5" : "R3", $sformatf("vec %0d style", i),
            coup, v.expCoupled);
      check(allHigh, "R4", $sformatf("vec %0d strobes freed", i), allHigh, 1);
      check(ready == v.expReady, "R10", $sformatf("vec %0d ready after end", i), ready, v.expReady);
      if (!v.wr && v.expRes == 1)
        check(rdData == v.data, "R6", $sformatf("vec %0d read data", i), rdData, v.data);
    end

    // R7: exact abort latency with no acknowledge, T = 5
    cfgTimeout = 8'd5; cfgCoupled16 = 1'b0;
    v = VECS[6];
    run_cycle(v, res, resN, coup, ready, allHigh);
    check(res == 2 && resN == 9, "R7", "abort count", resN, 9);

    // R9: acknowledge reaching the FSM on the expiry edge wins
    v = VECS[0]; v.ackAt = 8'd6;
    run_cycle(v, res, resN, coup, ready, allHigh);
    check(res == 1, "R9", "ack on expiry edge", res, 1);
    // one clock later is a timeout
    v.ackAt = 8'd7;
    run_cycle(v, res, resN, coup, ready, allHigh);
    check(res == 2, "R9", "ack one clock late", res, 2);
    check(!done, "R11", "no done with timeout", done, 0);

    // R10: request ignored while acknowledge held
    while (!reqReady) @(negedge clk);
    dtackN = 1'b0;
    repeat (3) @(negedge clk);
    reqAddr = 24'hFEDCBA; reqMod = 6'h29; reqValid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(asN && busAddr != 24'hFEDCBA && !reqReady, "R10", "request ignored",
            {asN, busAddr}, {1'b1, 24'h0});
    end
    reqValid = 1'b0;
    dtackN = 1'b1;
    repeat (3) @(negedge clk);
    check(reqReady, "R10", "ready after release", reqReady, 1);

    report();
  end

endmodule